// File: doc/BRIEF.md
# Event-Count Timer and Alarm Controller

This block holds the alarm control register of a real-time clock running as an event counter and acts on it. The event counter outside the block emits one carry strobe per decade it watches (units, hundreds, ten-thousands, millions). A three-bit source code in the control register picks one of those strobes to advance a secondary timer. A test code lets any strobe advance the timer. When the timer wraps, or when it reaches a programmed timer-alarm value, a sticky timer flag is set. When event alarm mode is selected, an event-count match from the counter sets a sticky alarm flag. Each flag can be routed to an active-low interrupt pin by its own enable bit.

The block has no streaming data path. Every pin is a plain control or status signal: a one-cycle write strobe with data for the control register, a one-cycle write strobe for clearing flags, level or pulse inputs from the counter, and registered flag outputs. There is no back-pressure anywhere. A write is always accepted on the clock edge where its strobe is high.

Top module: `ec_alarm_ctl`

## Requirements
- R1: After reset the control register is 0x00, the timer count is 0, both flags are 0 and `irq_n` is 1.
- R2: Control bit layout: bits [2:0] timer source, bit 3 timer interrupt enable, bits [5:4] event alarm mode, bit 6 timer alarm enable, bit 7 alarm interrupt enable. Source codes 1 to 4 select `dec_carry[code-1]`. Only that strobe advances the timer, by one per edge.
- R3: Source codes 0, 5 and 6 stop the timer. No strobe changes the count.
- R4: Source code 7 is test mode. On any edge where at least one strobe is high, the timer advances by exactly one.
- R5: The timer counts 0 to TMR_MAX and then wraps to 0. With timer alarm enable at 0, the wrap sets the timer flag.
- R6: With timer alarm enable at 1, the timer flag sets on the advance whose new count equals `tmr_alarm`, and the wrap does not set it.
- R7: With event alarm mode 01, `evt_match` high at an edge sets the alarm flag. With modes 00, 10 and 11, the match is ignored.
- R8: Flags are sticky. A `flg_we` pulse clears the timer flag where `flg_wdata[0]` is 0 and the alarm flag where `flg_wdata[1]` is 0. A set condition in the same cycle wins over the clear.
- R9: `irq_n` is 0 exactly when (timer flag and bit 3) or (alarm flag and bit 7). Changing the enables never changes the flags.
- R10: A control write takes effect from the next edge. A strobe in the same cycle as the write is judged by the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| flg_we | input | 1 | Flag clear strobe |
| flg_wdata | input | 2 | Flag keep mask (bit 0 timer, bit 1 alarm; 0 clears) |
| dec_carry | input | NDEC | Decade carry strobes, units first |
| evt_match | input | 1 | Event count equals alarm value |
| tmr_alarm | input | TW | Timer alarm compare value |
| tmr_count | output | TW | Current timer count |
| tmr_flag | output | 1 | Sticky timer flag |
| alm_flag | output | 1 | Sticky event alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A corrupted source decode shows at `tmr_count` on the first edge whose strobe is mis-steered: the count moves when it should hold, or holds when it should move. A wrong wrap or compare appears at `tmr_flag` on the edge of the offending advance. A flag that fails to stick, or that sets spuriously, shows at the flag pins one cycle after the stimulus, and in the same cycle at `irq_n` when its enable is set. The sweep drives every source code against every strobe and checks the ports after each edge, so any such error is reported on that edge.

// File: rtl/ec_alarm_pkg.sv
package ec_alarm_pkg;
  typedef struct packed {
    logic       aie;
    logic       talm_en;
    logic [1:0] amode;
    logic       tie;
    logic [2:0] tsrc;
  } actl_t;

  localparam logic [2:0] TSRC_TEST  = 3'b111;
  localparam logic [1:0] AMODE_EVT  = 2'b01;
endpackage

// File: rtl/ec_src_sel.sv
module ec_src_sel #(
  parameter int NDEC = 4
) (
  input  logic [2:0]      tsrc,
  input  logic [NDEC-1:0] strb,
  output logic            inc
);
  import ec_alarm_pkg::*;

  logic [NDEC-1:0] pick;

  for (genvar gi = 0; gi < NDEC; gi++) begin : g_dec
    assign pick[gi] = (tsrc == 3'(gi + 1)) & strb[gi];
  end

  assign inc = (|pick) | ((tsrc == TSRC_TEST) & (|strb));
endmodule

// File: rtl/ec_timer.sv
module ec_timer #(
  parameter int TW      = 8,
  parameter int TMR_MAX = 99
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          talm_en,
  input  logic [TW-1:0] alm_val,
  output logic [TW-1:0] cnt_q,
  output logic          hit
);
  localparam logic [TW-1:0] LIM = TW'(TMR_MAX);

  logic          wrap;
  logic [TW-1:0] nxt;

  assign wrap = (cnt_q == LIM);
  assign nxt  = wrap ? '0 : cnt_q + 1'b1;
  assign hit  = inc & (talm_en ? (nxt == alm_val) : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= nxt;
  end
endmodule

// File: rtl/ec_flags.sv
module ec_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       t_set,
  input  logic       a_set,
  input  logic       clr_we,
  input  logic [1:0] keep,
  input  logic       tie,
  input  logic       aie,
  output logic       tflag,
  output logic       aflag,
  output logic       irq_n
);
  logic t_clr, a_clr;

  assign t_clr = clr_we & ~keep[0];
  assign a_clr = clr_we & ~keep[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tflag <= 1'b0;
      aflag <= 1'b0;
    end else begin
      tflag <= t_set | (tflag & ~t_clr);
      aflag <= a_set | (aflag & ~a_clr);
    end
  end

  assign irq_n = ~((tflag & tie) | (aflag & aie));
endmodule

// File: rtl/ec_alarm_ctl.sv
module ec_alarm_ctl #(
  parameter int NDEC    = 4,
  parameter int TW      = 8,
  parameter int TMR_MAX = 99
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  input  logic            flg_we,
  input  logic [1:0]      flg_wdata,
  input  logic [NDEC-1:0] dec_carry,
  input  logic            evt_match,
  input  logic [TW-1:0]   tmr_alarm,
  output logic [TW-1:0]   tmr_count,
  output logic            tmr_flag,
  output logic            alm_flag,
  output logic            irq_n
);
  import ec_alarm_pkg::*;

  logic [7:0] ctl_q;
  actl_t      ctl;
  logic       tinc, thit, ahit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= 8'h00;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign ctl  = actl_t'(ctl_q);
  assign ahit = evt_match & (ctl.amode == AMODE_EVT);

  ec_src_sel #(.NDEC(NDEC)) u_sel (
    .tsrc (ctl.tsrc),
    .strb (dec_carry),
    .inc  (tinc)
  );

  ec_timer #(.TW(TW), .TMR_MAX(TMR_MAX)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tinc),
    .talm_en (ctl.talm_en),
    .alm_val (tmr_alarm),
    .cnt_q   (tmr_count),
    .hit     (thit)
  );

  ec_flags u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .t_set  (thit),
    .a_set  (ahit),
    .clr_we (flg_we),
    .keep   (flg_wdata),
    .tie    (ctl.tie),
    .aie    (ctl.aie),
    .tflag  (tmr_flag),
    .aflag  (alm_flag),
    .irq_n  (irq_n)
  );
endmodule

// File: rtl/ec_alarm_ctl_chk.sv
module ec_alarm_ctl_chk #(
  parameter int TW      = 8,
  parameter int TMR_MAX = 99
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flg_we,
  input logic [1:0]    flg_wdata,
  input logic [2:0]    tsrc,
  input logic [1:0]    amode,
  input logic [TW-1:0] tmr_count,
  input logic          tmr_flag,
  input logic          alm_flag,
  input logic          irq_n
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset: assert (tmr_count == '0 && !tmr_flag && !alm_flag && irq_n)
        else $error("reset state wrong");
    end
  end

  a_r3_timer_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tsrc == 3'd0 || tsrc == 3'd5 || tsrc == 3'd6) |=> $stable(tmr_count));

  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_count <= TW'(TMR_MAX));

  a_r7_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (amode != 2'b01 && !alm_flag) |=> !alm_flag);

  a_r8_tflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !(flg_we && !flg_wdata[0])) |=> tmr_flag);

  a_r8_aflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !(flg_we && !flg_wdata[1])) |=> alm_flag);

  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_flag && !alm_flag) |-> irq_n);
endmodule

bind ec_alarm_ctl ec_alarm_ctl_chk #(.TW(TW), .TMR_MAX(TMR_MAX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flg_we    (flg_we),
  .flg_wdata (flg_wdata),
  .tsrc      (ctl_q[2:0]),
  .amode     (ctl_q[5:4]),
  .tmr_count (tmr_count),
  .tmr_flag  (tmr_flag),
  .alm_flag  (alm_flag),
  .irq_n     (irq_n)
);

// File: tb/sim_ec_alarm_ctl.sv
`timescale 1ns/1ps
module sim_ec_alarm_ctl;
  localparam int NDEC = 4, TW = 8, MAXV = 99;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, flg_we = 0, evt_match = 0;
  logic [7:0] ctl_wdata = '0;
  logic [1:0] flg_wdata = '0;
  logic [NDEC-1:0] dec_carry = '0;
  logic [TW-1:0] tmr_alarm = '0;
  logic [TW-1:0] tmr_count;
  logic tmr_flag, alm_flag, irq_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // expected state
  int   m_cnt = 0;
  bit   m_tf = 0, m_af = 0;
  logic [7:0] m_ctl = 8'h00;

  always #4 clk = ~clk;

  ec_alarm_ctl #(.NDEC(NDEC), .TW(TW), .TMR_MAX(MAXV)) u0 (
    .clk, .rst_n, .ctl_we, .ctl_wdata, .flg_we, .flg_wdata,
    .dec_carry, .evt_match, .tmr_alarm,
    .tmr_count, .tmr_flag, .alm_flag, .irq_n
  );

  task automatic check(string req);
    bit eirq;
    eirq = !((m_tf && m_ctl[3]) || (m_af && m_ctl[7]));
    n_run++;
    if (tmr_count != TW'(m_cnt) || tmr_flag != m_tf || alm_flag != m_af || irq_n != eirq) begin
      n_fail++;
      $display("FAIL %s: cnt/tf/af/irq_n = %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
               req, tmr_count, tmr_flag, alm_flag, irq_n, m_cnt, m_tf, m_af, eirq);
    end
  endtask

  // called at a negedge; applies one edge of stimulus and checks at the next negedge
  task automatic step(string req, logic [NDEC-1:0] st, bit mt,
                      bit cw, logic [7:0] cwd, bit fw, logic [1:0] fwd);
    bit inc, wrap, thit;
    int nxt, src;
    dec_carry = st; evt_match = mt; ctl_we = cw; ctl_wdata = cwd;
    flg_we = fw; flg_wdata = fwd;
    src = int'(m_ctl[2:0]);
    if (src >= 1 && src <= NDEC) inc = st[src-1];
    else if (src == 7)           inc = |st;
    else                         inc = 0;
    thit = 0;
    if (inc) begin
      wrap = (m_cnt == MAXV);
      nxt  = wrap ? 0 : m_cnt + 1;
      thit = m_ctl[6] ? (nxt == int'(tmr_alarm)) : wrap;
      m_cnt = nxt;
    end
    m_tf = thit || (m_tf && !(fw && !fwd[0]));
    m_af = (mt && m_ctl[5:4] == 2'b01) || (m_af && !(fw && !fwd[1]));
    if (cw) m_ctl = cwd;
    @(negedge clk);
    dec_carry = '0; evt_match = 0; ctl_we = 0; flg_we = 0;
    check(req);
  endtask

  task automatic wr_ctl(string req, logic [7:0] v);
    step(req, '0, 0, 1, v, 0, 2'b11);
  endtask

  task automatic clr_flags(string req);
    step(req, '0, 0, 0, 8'h00, 1, 2'b00);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1");            // reset held
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2/R3/R4: every source code against every single strobe
    for (int code = 0; code < 8; code++) begin
      wr_ctl("R2", 8'(code));
      for (int b = 0; b < NDEC; b++) begin
        if (code >= 1 && code <= 4)      step("R2", NDEC'(1) << b, 0, 0, 0, 0, 2'b11);
        else if (code == 7)              step("R4", NDEC'(1) << b, 0, 0, 0, 0, 2'b11);
        else                             step("R3", NDEC'(1) << b, 0, 0, 0, 0, 2'b11);
      end
      step(code == 7 ? "R4" : "R3", '1, 0, 0, 0, 0, 2'b11);
    end

    // R10: write in the same cycle as a strobe uses the old code
    wr_ctl("R10", 8'h00);
    step("R10", 4'b0001, 0, 1, 8'h01, 0, 2'b11);
    step("R10", 4'b0001, 0, 1, 8'h00, 0, 2'b11);

    // R5: run through the wrap with units source
    clr_flags("R8");
    wr_ctl("R5", 8'h01);
    for (int i = 0; i < 120; i++) step("R5", 4'b0001, 0, 0, 0, 0, 2'b11);
    clr_flags("R8");

    // R6: compare against tmr_alarm, wrap ignored
    tmr_alarm = 8'd5;
    wr_ctl("R6", 8'h41);
    for (int i = 0; i < 110; i++) step("R6", 4'b0001, 0, 0, 0, 0, 2'b11);

    // R8: selective clear, and set wins over clear
    clr_flags("R8");
    wr_ctl("R8", 8'h10);
    step("R8", '0, 1, 0, 0, 0, 2'b11);
    step("R8", '0, 0, 0, 0, 1, 2'b01);   // keeps nothing of alarm
    step("R8", '0, 1, 0, 0, 1, 2'b00);   // set and clear together
    step("R8", '0, 0, 0, 0, 1, 2'b10);

    // R7: every alarm mode against a match
    for (int m = 0; m < 4; m++) begin
      clr_flags("R7");
      wr_ctl("R7", 8'(m << 4));
      step("R7", '0, 1, 0, 0, 0, 2'b11);
    end

    // R9: every flag/enable combination
    for (int k = 0; k < 16; k++) begin
      clr_flags("R9");
      tmr_alarm = TW'((m_cnt == MAXV) ? 0 : m_cnt + 1);
      wr_ctl("R9", {k[3], 1'b1, 2'b01, k[2], 3'b001});
      step("R9", {3'b000, k[0]}, k[1], 0, 0, 0, 2'b11);
      wr_ctl("R9", {~k[3], 1'b1, 2'b01, ~k[2], 3'b001});
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule